// File: doc/BRIEF.md
# Fractional Audio Master Clock Divider

The block turns a fast source clock into an audio master clock. It does this by emitting single-cycle enable pulses whose average rate is the source rate times a numerator over a denominator. A phase accumulator gains the numerator on every enabled source cycle. When the accumulator reaches the denominator, the block subtracts the denominator and emits one master clock enable pulse. A second stage counts these pulses and toggles a bit clock level. The bit clock ratio is always even, and it is programmed as a code equal to half the ratio minus one.

Software loads a new numerator and denominator with a one-cycle write strobe. The block holds the new pair as pending and applies it only when the accumulator wraps. At that point the accumulator restarts from zero and a done flag reports that the ratio is in force. If the enable input is low, a pending pair is applied on the next cycle. Pairs that are out of range or not a proper fraction are dropped.

Top module: `frac_mclk_div`

## Requirements
- R1: After reset, `mclk_en`, `bclk` and `bclk_en` are 0, `upd_done` is 1, and the active ratio is 1/1.
- R2: Starting from a zero accumulator, N enabled source cycles produce exactly floor(N*F/D) `mclk_en` pulses. When F equals D, a pulse comes in every enabled cycle.
- R3: While `en` is low, `mclk_en` stays 0 and `bclk` holds its level.
- R4: `bclk` changes level only in a cycle where `mclk_en` is 1. It changes once every `bdiv_code`+1 pulses, so the bit clock ratio is 2*(`bdiv_code`+1).
- R5: An accepted write drives `upd_done` to 0 at the next edge. While `en` is high, the new pair takes effect at the next accumulator wrap under the old pair. At that same edge `upd_done` returns to 1 and the accumulator restarts at zero.
- R6: A write is rejected if F is 0, D is 0, F > D, F > 256 or D > 4096. A rejected write leaves `upd_done` and the active ratio unchanged.
- R7: While `en` is low, a pending pair is applied at the edge after the write was accepted, and `upd_done` is then 1.
- R8: `bclk_en` is 1 for exactly the cycles in which `bclk` has just risen from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable for accumulator and bit clock |
| ratio_wr | input | 1 | One-cycle strobe that loads `fract_in`/`divide_in` |
| fract_in | input | FRACT_W | Numerator F |
| divide_in | input | DIV_W | Denominator D |
| bdiv_code | input | BDIV_W | Bit clock code: ratio/2 - 1 |
| mclk_en | output | 1 | Master clock enable pulse |
| bclk | output | 1 | Bit clock level |
| bclk_en | output | 1 | Pulse on each bit clock rising edge |
| upd_done | output | 1 | Ratio update has taken effect |

## Verification
The bench uses the default parameters: a 9-bit numerator, a 13-bit denominator and an 8-bit bit clock code. With these widths the extreme legal pair 256/4096 can be loaded. The out-of-range values 300 and 5000 can also be encoded, so the range checks are exercised rather than masked by port width. Long windows at coprime ratios such as 3/7 and 128/4095 test exact long-run pulse counts, and ratio 5/5 tests the every-cycle case. One directed sequence places a write mid-period to measure precisely when the wrap applies the new ratio.

// File: rtl/frac_mclk_div.sv
module frac_mclk_div #(
  parameter int FRACT_W   = 9,
  parameter int DIV_W     = 13,
  parameter int BDIV_W    = 8,
  parameter int FRACT_MAX = 256,
  parameter int DIV_MAX   = 4096
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               ratio_wr,
  input  logic [FRACT_W-1:0] fract_in,
  input  logic [DIV_W-1:0]   divide_in,
  input  logic [BDIV_W-1:0]  bdiv_code,
  output logic               mclk_en,
  output logic               bclk,
  output logic               bclk_en,
  output logic               upd_done
);

  localparam int ACC_W = DIV_W + 1;
  localparam logic [FRACT_W-1:0] F_LIM = FRACT_W'(FRACT_MAX);
  localparam logic [DIV_W-1:0]   D_LIM = DIV_W'(DIV_MAX);

  logic [FRACT_W-1:0] act_f, pend_f;
  logic [DIV_W-1:0]   act_d, pend_d;
  logic               pend_v;
  logic [ACC_W-1:0]   acc;
  logic [BDIV_W-1:0]  bcnt;

  wire [ACC_W-1:0] sum   = acc + ACC_W'(act_f);
  wire             wrap  = en && (sum >= ACC_W'(act_d));
  wire             wr_ok = ratio_wr && (fract_in != '0) && (divide_in != '0) &&
                           (fract_in <= F_LIM) && (divide_in <= D_LIM) &&
                           (ACC_W'(fract_in) <= ACC_W'(divide_in));
  wire             apply = pend_v && !wr_ok && (wrap || !en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_f    <= FRACT_W'(1);
      act_d    <= DIV_W'(1);
      pend_f   <= '0;
      pend_d   <= '0;
      pend_v   <= 1'b0;
      acc      <= '0;
      mclk_en  <= 1'b0;
      bcnt     <= '0;
      bclk     <= 1'b0;
      bclk_en  <= 1'b0;
      upd_done <= 1'b1;
    end else begin
      mclk_en <= wrap;
      bclk_en <= 1'b0;
      if (en) acc <= wrap ? (sum - ACC_W'(act_d)) : sum;
      if (wr_ok) begin
        pend_f   <= fract_in;
        pend_d   <= divide_in;
        pend_v   <= 1'b1;
        upd_done <= 1'b0;
      end else if (apply) begin
        act_f    <= pend_f;
        act_d    <= pend_d;
        pend_v   <= 1'b0;
        acc      <= '0;
        upd_done <= 1'b1;
      end
      if (wrap) begin
        if (bcnt >= bdiv_code) begin
          bcnt    <= '0;
          bclk    <= ~bclk;
          bclk_en <= ~bclk;
        end else begin
          bcnt <= bcnt + 1'b1;
        end
      end
    end
  end

  // R5
  upd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> !upd_done);

  // R3
  gate_mclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !mclk_en);

  // R3
  gate_bclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(bclk));

  // R4
  bclk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk != $past(bclk)) |-> mclk_en);

  // R8
  bclk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_en |-> (bclk && !$past(bclk)));

  // R6
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_wr && !wr_ok && !pend_v) |=> $stable(upd_done));

  // R2
  acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc < ACC_W'(act_d));

endmodule

// File: tb/frac_mclk_div_tb.sv
module frac_mclk_div_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        ratio_wr = 1'b0;
  logic [8:0]  fract_in = '0;
  logic [12:0] divide_in = '0;
  logic [7:0]  bdiv_code = '0;
  logic        mclk_en, bclk, bclk_en, upd_done;

  int checks = 0;
  int fails  = 0;
  int m_pulses, m_toggles, m_rises, m_ben, m_ben_bad;

  always #(CLK_PERIOD/2) clk = ~clk;

  frac_mclk_div dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .ratio_wr(ratio_wr),
    .fract_in(fract_in), .divide_in(divide_in), .bdiv_code(bdiv_code),
    .mclk_en(mclk_en), .bclk(bclk), .bclk_en(bclk_en), .upd_done(upd_done)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; en = 1'b0; ratio_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic write_ratio(input int f, input int d);
    ratio_wr  = 1'b1;
    fract_in  = 9'(f);
    divide_in = 13'(d);
    @(posedge clk);
    @(negedge clk);
    ratio_wr = 1'b0;
  endtask

  task automatic measure(input int n);
    logic prev;
    prev = bclk;
    m_pulses = 0; m_toggles = 0; m_rises = 0; m_ben = 0; m_ben_bad = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (mclk_en) m_pulses++;
      if (bclk != prev) m_toggles++;
      if (bclk && !prev) m_rises++;
      if (bclk_en) m_ben++;
      if (bclk_en != (bclk && !prev)) m_ben_bad++;
      prev = bclk;
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 mclk_en", mclk_en, 0);
    chk("R1 bclk", bclk, 0);
    chk("R1 bclk_en", bclk_en, 0);
    chk("R1 upd_done", upd_done, 1);
    en = 1'b1;
    measure(10);
    chk("R1 default ratio 1/1 pulses", m_pulses, 10);
  endtask

  task automatic t_ratio(input int f, input int d, input int n, input int code);
    do_reset();
    bdiv_code = 8'(code);
    write_ratio(f, d);
    chk("R5 upd_done cleared", upd_done, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R7 applied while idle", upd_done, 1);
    en = 1'b1;
    measure(n);
    chk("R2 pulse count", m_pulses, (longint'(n) * f) / d);
    chk("R4 bclk toggles", m_toggles, m_pulses / (code + 1));
    chk("R8 bclk_en count", m_ben, m_rises);
    chk("R8 bclk_en placement", m_ben_bad, 0);
  endtask

  task automatic t_gate();
    logic hold;
    do_reset();
    bdiv_code = 8'd0;
    write_ratio(1, 2);
    @(negedge clk);
    en = 1'b1;
    measure(9);
    en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    hold = bclk;
    measure(20);
    chk("R3 no pulses while disabled", m_pulses, 0);
    chk("R3 bclk held", m_toggles, 0);
    chk("R3 bclk level", bclk, hold);
  endtask

  task automatic t_update();
    int k;
    do_reset();
    write_ratio(1, 8);
    @(negedge clk);
    en = 1'b1;
    measure(8);
    chk("R2 one pulse per 8", m_pulses, 1);
    write_ratio(1, 2);
    chk("R5 cleared after write", upd_done, 0);
    k = 0;
    while (!upd_done && k < 50) begin
      @(posedge clk);
      @(negedge clk);
      k++;
    end
    chk("R5 edges until wrap applies", k, 7);
    measure(20);
    chk("R5 new ratio 1/2 in force", m_pulses, 10);
  endtask

  task automatic t_reject();
    do_reset();
    write_ratio(1, 4);
    @(negedge clk);
    write_ratio(5, 4);
    chk("R6 F>D upd_done", upd_done, 1);
    write_ratio(0, 4);
    chk("R6 F=0 upd_done", upd_done, 1);
    write_ratio(3, 0);
    chk("R6 D=0 upd_done", upd_done, 1);
    write_ratio(300, 4000);
    chk("R6 F>256 upd_done", upd_done, 1);
    write_ratio(2, 5000);
    chk("R6 D>4096 upd_done", upd_done, 1);
    @(negedge clk);
    chk("R6 still done", upd_done, 1);
    en = 1'b1;
    measure(40);
    chk("R6 ratio 1/4 kept", m_pulses, 10);
  endtask

  initial begin
    t_reset();
    t_ratio(3, 7, 700, 0);
    t_ratio(256, 4096, 2000, 1);
    t_ratio(5, 5, 50, 2);
    t_ratio(128, 4095, 3000, 3);
    t_gate();
    t_update();
    t_reject();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule